// File: doc/BRIEF.md
# Accumulator Load/Store Sequencer

This block is the control and datapath of a small accumulator processor that works against a memory of unknown and varying response time. It holds a program counter, an address holding register that drives the memory address pins, a data holding register that captures read data and drives write data, an instruction register and an accumulator. A state machine steps through instruction fetch, decode and operand access.

Every memory access is a handshake. The sequencer puts the address out, raises exactly one of the read or write strobes, and then stays where it is until the memory raises its completion input. It only treats read data as valid in the cycle where completion is high. Instruction words are 15 bits wide: the opcode sits in bits 14:12 and the operand address in bits 11:0. LOAD (000) reads the operand into the accumulator and STORE (001) writes the accumulator to the operand address. Every other opcode only moves to the next instruction. The program counter starts at zero and wraps at the top of the 12-bit address space.

Top module: `acc_seq_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, address register and data register. In the cycle after reset is sampled, both strobes are low and `mem_addr` is 0. The first access after release is a read of address 0.
- R2: Each instruction fetch is a read whose address is the current program counter value, driven from the address register onto `mem_addr`.
- R3: `mem_rd` and `mem_wr` are never high in the same cycle.
- R4: While a strobe is high and `mem_mfc` is low, the next cycle keeps the same strobe, the same `mem_addr` and, during a write, the same `mem_wdata`.
- R5: In the cycle after `mem_mfc` is sampled high with a strobe raised, both strobes are low.
- R6: An instruction with opcode 000 in bits 14:12 reads the word at the address in bits 11:0 and places it in the accumulator.
- R7: An instruction with opcode 001 drives the accumulator value on `mem_wdata` with `mem_wr` high, at the address in bits 11:0.
- R8: Opcodes 010 through 111 make no operand access and leave the accumulator unchanged.
- R9: The program counter advances by exactly one per completed instruction and wraps from 4095 to 0. It does not change at any other time.
- R10: Values on `mem_rdata` in cycles where `mem_mfc` is low have no effect, and the results do not depend on the completion delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 15 | Write data, driven from the data register |
| mem_rdata | input | 15 | Read data from memory |
| mem_mfc | input | 1 | Memory completion acknowledge |

## Verification
The hardest case to reach from the ports is the program counter wrapping from 4095 to 0 while the accumulator must keep a value loaded thousands of instructions earlier. The stimulus fills all of memory with operand-free opcodes and places a LOAD at address 0 and a STORE at 4094. The store then brings the accumulator out on the write port after the full lap. Wait-state corners are reached by a memory model that answers with a random or swept fixed delay of 0 to 7 cycles and drives junk on the read data while the acknowledge is low.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 3'b000;
  localparam logic [OPC_W-1:0] OPC_STORE = 3'b001;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_WAIT,
    ST_DECODE,
    ST_EXEC,
    ST_OPND_RD,
    ST_LOAD_WB,
    ST_OPND_WR
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_NOP,
    KIND_LOAD,
    KIND_STORE
  } instr_kind_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_acc;
    logic ir_load;
    logic acc_load;
    logic pc_step;
  } seq_ctl_t;

  function automatic instr_kind_e decode_kind(input logic [OPC_W-1:0] op);
    if (op == OPC_LOAD)       return KIND_LOAD;
    else if (op == OPC_STORE) return KIND_STORE;
    else                      return KIND_NOP;
  endfunction

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] op_i,
  input  logic             mfc_i,
  output seq_ctl_t         ctl_o,
  output logic             rd_o,
  output logic             wr_o
);

  seq_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FETCH_ADDR;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d  = st_q;
    ctl_o = '0;
    rd_o  = 1'b0;
    wr_o  = 1'b0;
    unique case (st_q)
      ST_FETCH_ADDR: begin
        ctl_o.mar_from_pc = 1'b1;
        st_d = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: begin
        rd_o = 1'b1;
        if (mfc_i) begin
          ctl_o.mbr_from_mem = 1'b1;
          st_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        ctl_o.ir_load = 1'b1;
        st_d = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (decode_kind(op_i))
          KIND_LOAD: begin
            ctl_o.mar_from_ir = 1'b1;
            st_d = ST_OPND_RD;
          end
          KIND_STORE: begin
            ctl_o.mar_from_ir  = 1'b1;
            ctl_o.mbr_from_acc = 1'b1;
            st_d = ST_OPND_WR;
          end
          default: begin
            ctl_o.pc_step = 1'b1;
            st_d = ST_FETCH_ADDR;
          end
        endcase
      end
      ST_OPND_RD: begin
        rd_o = 1'b1;
        if (mfc_i) begin
          ctl_o.mbr_from_mem = 1'b1;
          st_d = ST_LOAD_WB;
        end
      end
      ST_LOAD_WB: begin
        ctl_o.acc_load = 1'b1;
        ctl_o.pc_step  = 1'b1;
        st_d = ST_FETCH_ADDR;
      end
      ST_OPND_WR: begin
        wr_o = 1'b1;
        if (mfc_i) begin
          ctl_o.pc_step = 1'b1;
          st_d = ST_FETCH_ADDR;
        end
      end
      default: st_d = ST_FETCH_ADDR;
    endcase
  end

endmodule

// File: rtl/acc_seq_regs.sv
module acc_seq_regs
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [OPC_W-1:0]  op_o
);

  logic [DATA_W-1:0] ir_q;

  function automatic logic [ADDR_W-1:0] pc_succ(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] operand_of(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [OPC_W-1:0] opcode_of(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: OPC_W];
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                pc_o <= '0;
    else if (ctl_i.pc_step) pc_o <= pc_succ(pc_o);
  end

  always_ff @(posedge clk) begin
    if (rst)                    mar_o <= '0;
    else if (ctl_i.mar_from_pc) mar_o <= pc_o;
    else if (ctl_i.mar_from_ir) mar_o <= operand_of(ir_q);
  end

  always_ff @(posedge clk) begin
    if (rst)                     mbr_o <= '0;
    else if (ctl_i.mbr_from_mem) mbr_o <= rdata_i;
    else if (ctl_i.mbr_from_acc) mbr_o <= acc_o;
  end

  always_ff @(posedge clk) begin
    if (rst)                ir_q <= '0;
    else if (ctl_i.ir_load) ir_q <= mbr_o;
  end

  always_ff @(posedge clk) begin
    if (rst)                 acc_o <= '0;
    else if (ctl_i.acc_load) acc_o <= mbr_o;
  end

  assign op_o = opcode_of(ir_q);

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_mfc
);

  seq_ctl_t          ctl;
  logic [OPC_W-1:0]  op_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q;
  logic [DATA_W-1:0] acc_q;

  // Named events for the bound checker
  logic fetch_start;
  logic load_commit;
  logic instr_retire;

  acc_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op_q),
    .mfc_i (mem_mfc),
    .ctl_o (ctl),
    .rd_o  (mem_rd),
    .wr_o  (mem_wr)
  );

  acc_seq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ctl_i   (ctl),
    .rdata_i (mem_rdata),
    .pc_o    (pc_q),
    .mar_o   (mar_q),
    .mbr_o   (mbr_q),
    .acc_o   (acc_q),
    .op_o    (op_q)
  );

  assign mem_addr     = mar_q;
  assign mem_wdata    = mbr_q;
  assign fetch_start  = ctl.mar_from_pc;
  assign load_commit  = ctl.acc_load;
  assign instr_retire = ctl.pc_step;

endmodule

// File: rtl/acc_seq_checker.sv
module acc_seq_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_mfc,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] acc_q,
  input logic [DATA_W-1:0] mbr_q,
  input logic              fetch_start,
  input logic              load_commit,
  input logic              instr_retire
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!mem_rd && !mem_wr && mem_addr == '0));

  assert_fetch_pc_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_start |=> (mem_rd && mem_addr == $past(pc_q)));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_hold_wait_R4: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_mfc) |=>
      ($stable(mem_addr) && mem_rd == $past(mem_rd) && mem_wr == $past(mem_wr)
       && (!mem_wr || $stable(mem_wdata))));

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_mfc) |=> (!mem_rd && !mem_wr));

  assert_load_acc_R6: assert property (@(posedge clk) disable iff (rst)
    load_commit |=> (acc_q == $past(mbr_q)));

  assert_store_data_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == acc_q));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    instr_retire |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !instr_retire |=> $stable(pc_q));

endmodule

bind acc_seq_core acc_seq_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_addr     (mem_addr),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .mem_wdata    (mem_wdata),
  .mem_mfc      (mem_mfc),
  .pc_q         (pc_q),
  .acc_q        (acc_q),
  .mbr_q        (mbr_q),
  .fetch_start  (fetch_start),
  .load_commit  (load_commit),
  .instr_retire (instr_retire)
);

// File: tb/acc_seq_core_tb_top.sv
module acc_seq_core_tb_top;
  localparam int AW    = 12;
  localparam int DW    = 15;
  localparam int MEM_N = 1 << AW;
  localparam int LOG_N = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_mfc = 1'b0;

  acc_seq_core #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_mfc   (mem_mfc)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [DW-1:0] mem     [MEM_N];
  logic [DW-1:0] ref_mem [MEM_N];

  bit            log_wr   [LOG_N];
  logic [AW-1:0] log_addr [LOG_N];
  logic [DW-1:0] log_data [LOG_N];
  int            n_log = 0;

  bit            exp_wr   [LOG_N];
  logic [AW-1:0] exp_addr [LOG_N];
  logic [DW-1:0] exp_data [LOG_N];

  int fixed_lat = -1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model with variable completion delay
  bit            busy = 1'b0, done_prev = 1'b0;
  int            wcnt = 0, lat = 0;
  logic [AW-1:0] s_addr;
  logic          s_rd, s_wr;
  logic [DW-1:0] s_wdata;

  always @(negedge clk) begin
    if (rst) begin
      mem_mfc = 1'b0; busy = 1'b0; done_prev = 1'b0; mem_rdata = '0;
    end else begin
      if (done_prev)
        check(!mem_rd && !mem_wr, "R5", "strobe after ack", {mem_rd, mem_wr}, 0);
      if (busy)
        check(mem_addr == s_addr && mem_rd == s_rd && mem_wr == s_wr &&
              (!s_wr || mem_wdata == s_wdata), "R4", "hold during wait",
              {mem_rd, mem_wr, mem_addr}, {s_rd, s_wr, s_addr});
      if (mem_rd || mem_wr)
        check(!(mem_rd && mem_wr), "R3", "both strobes", {mem_rd, mem_wr}, 0);
      done_prev = 1'b0;
      if (mem_rd || mem_wr) begin
        if (!busy) begin
          busy = 1'b1; wcnt = 0;
          lat = (fixed_lat >= 0) ? fixed_lat : int'($urandom_range(7, 0));
          s_addr = mem_addr; s_rd = mem_rd; s_wr = mem_wr; s_wdata = mem_wdata;
        end
        if (wcnt >= lat) begin
          mem_mfc = 1'b1;
          if (mem_rd) mem_rdata = mem[mem_addr];
          else        mem[mem_addr] = mem_wdata;
          if (n_log < LOG_N) begin
            log_wr[n_log]   = mem_wr;
            log_addr[n_log] = mem_addr;
            log_data[n_log] = mem_rd ? mem[mem_addr] : mem_wdata;
          end
          n_log++;
          busy = 1'b0; done_prev = 1'b1;
        end else begin
          mem_mfc = 1'b0; mem_rdata = DW'($urandom); wcnt++;
        end
      end else begin
        mem_mfc = 1'b0; mem_rdata = DW'($urandom);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      check(1'b0, "R9", "watchdog expired", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [DW-1:0] instr(input logic [2:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic hold_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic fill_nops();
    for (int i = 0; i < MEM_N; i++)
      mem[i] = instr(3'(2 + (i % 6)), AW'($urandom));
  endtask

  // Independent instruction-level model, then trace comparison
  task automatic run_program(input int n_instr, input string name);
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] acc = '0;
    logic [DW-1:0] w;
    int n = 0;
    int waited = 0;
    for (int i = 0; i < MEM_N; i++) ref_mem[i] = mem[i];
    for (int k = 0; k < n_instr; k++) begin
      w = ref_mem[pc];
      exp_wr[n] = 1'b0; exp_addr[n] = pc; exp_data[n] = w; n++;
      if (w[DW-1 -: 3] == 3'b000) begin
        acc = ref_mem[w[AW-1:0]];
        exp_wr[n] = 1'b0; exp_addr[n] = w[AW-1:0]; exp_data[n] = acc; n++;
      end else if (w[DW-1 -: 3] == 3'b001) begin
        ref_mem[w[AW-1:0]] = acc;
        exp_wr[n] = 1'b1; exp_addr[n] = w[AW-1:0]; exp_data[n] = acc; n++;
      end
      pc = pc + 1'b1;
    end
    n_log = 0;
    @(negedge clk); rst = 1'b0;
    while (n_log < n && waited < 60000) begin
      @(negedge clk); waited++;
    end
    check(n_log >= n, "R10", {name, " access count"}, n_log, n);
    for (int i = 0; i < n && i < n_log; i++) begin
      string req;
      if (exp_wr[i])                         req = "R7";
      else if (i > 0 && exp_addr[i] != exp_addr[i-1] + 1'b1 && i != 0 && !exp_wr[i] &&
               exp_data[i] === exp_data[i])  req = "R2";
      else                                   req = "R9";
      check(log_wr[i] == exp_wr[i] && log_addr[i] == exp_addr[i] && log_data[i] == exp_data[i],
            req, {name, " access trace"}, {log_wr[i], log_addr[i], log_data[i]},
            {exp_wr[i], exp_addr[i], exp_data[i]});
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
    check(mem_addr == '0, "R1", "address in reset", mem_addr, 0);
    fill_nops();
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check(mem_rd && mem_addr == '0, "R1", "first fetch at 0", {mem_rd, mem_addr}, {1'b1, 12'h000});
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!mem_rd && !mem_wr && mem_addr == '0, "R1", "reset mid-run",
          {mem_rd, mem_wr, mem_addr}, 0);
  endtask

  task automatic t_load_ff0();
    hold_reset();
    fill_nops();
    mem[0]      = instr(3'b000, 12'hFF0);
    mem[1]      = instr(3'b001, 12'h100);
    mem[2]      = instr(3'b101, 12'h0FF);
    mem[12'hFF0] = 15'h2A5C;
    run_program(3, "load_ff0");
    check(mem[12'h100] == 15'h2A5C, "R6", "word at 0xFF0 reached accumulator",
          mem[12'h100], 15'h2A5C);
  endtask

  task automatic t_store_path();
    hold_reset();
    fill_nops();
    mem[0] = instr(3'b000, 12'h800);
    mem[1] = instr(3'b001, 12'h900);
    mem[2] = instr(3'b000, 12'h801);
    mem[3] = instr(3'b001, 12'h901);
    mem[4] = instr(3'b001, 12'h902);
    mem[12'h800] = 15'h7FFF;
    mem[12'h801] = 15'h1001;
    run_program(5, "store_path");
    check(mem[12'h900] == 15'h7FFF, "R7", "first store", mem[12'h900], 15'h7FFF);
    check(mem[12'h901] == 15'h1001, "R7", "second store", mem[12'h901], 15'h1001);
    check(mem[12'h902] == 15'h1001, "R7", "repeat store", mem[12'h902], 15'h1001);
  endtask

  task automatic t_nop_wrap();
    logic [DW-1:0] held;
    hold_reset();
    fill_nops();
    mem[0]        = instr(3'b000, 12'hABC);
    mem[12'hFFE]  = instr(3'b001, 12'h7FF);
    held = mem[12'hABC];
    run_program(MEM_N + 2, "nop_wrap");
    check(mem[12'h7FF] == held, "R8", "accumulator kept across opcodes 010..111",
          mem[12'h7FF], held);
  endtask

  task automatic t_latency_sweep();
    for (int l = 0; l < 8; l++) begin
      hold_reset();
      fill_nops();
      fixed_lat = l;
      mem[0] = instr(3'b000, 12'h0A0);
      mem[1] = instr(3'b110, 12'h0A0);
      mem[2] = instr(3'b001, 12'h0B0);
      mem[3] = instr(3'b011, 12'h000);
      mem[12'h0A0] = DW'(15'h0123 + l);
      run_program(4, "latency");
      check(mem[12'h0B0] == DW'(15'h0123 + l), "R10", "result under fixed delay",
            mem[12'h0B0], DW'(15'h0123 + l));
    end
    fixed_lat = -1;
  endtask

  task automatic t_random_prog();
    hold_reset();
    fill_nops();
    for (int i = 0; i < 40; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(3, 0));
      if (op > 3'd1) op = 3'($urandom_range(7, 2));
      mem[i] = instr(op, AW'($urandom_range(MEM_N - 1, 64)));
    end
    run_program(40, "random_prog");
  endtask

  initial begin
    t_reset();
    t_load_ff0();
    t_store_path();
    t_latency_sweep();
    t_random_prog();
    t_nop_wrap();
    hold_reset();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule